// File: doc/BRIEF.md
# Tournament Conditional Branch Predictor

This block gives a taken or not-taken guess for a conditional branch while it is being fetched. It runs two direction predictors side by side. The first is a per-address table of 2-bit saturating counters, selected by the low bits of the branch address. The second is a pattern table of the same kind of counters, selected by a shift register that holds the most recent resolved outcomes. A third table, also selected by the branch address, holds 2-bit chooser counters. Each chooser counter records which of the two predictors has been right more often for that branch, and picks which one supplies the final guess.

The fetch stage presents the low address bits on the predict port. In the same cycle it receives the final direction, both component directions and the three table indices. It keeps these with the branch. When the branch resolves, the pipeline returns them on the update port together with the real outcome. The block then trains its counters, shifts the outcome into the history and raises a one-cycle mispredict flag if the final guess was wrong. The flush itself is left to the pipeline.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every local and pattern counter holds 1 (weakly not-taken), every chooser counter holds 1 (weakly favouring the local predictor), the history is 0 and `mispredict` is 0.
- R2: `predLocalIdx` and `predChooseIdx` equal `predPc`, the low address bits of the branch.
- R3: Counters are 2 bits wide and encoded 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken. A counter predicts taken when its value is 2 or 3. On a taken outcome it adds one, saturating at 3. On a not-taken outcome it subtracts one, saturating at 0. Both the local counter and the pattern counter named by the update are trained on every update.
- R4: The history register has HIST_LEN bits and indexes the pattern table directly, and `predGlobalIdx` shows it. Each update shifts the outcome into bit 0 (taken is 1) and drops the oldest bit.
- R5: The final direction is the local direction when bit 1 of the chooser counter is 0, and the pattern direction when that bit is 1.
- R6: A chooser counter changes only on an update where the two component directions differ. It steps toward the pattern predictor (+1, saturating at 3) when the pattern direction matched the outcome, and toward the local predictor (-1, saturating at 0) when the local direction matched.
- R7: `mispredict` is high for exactly the one cycle after an update whose returned final direction differs from the outcome, and is low in every other cycle.
- R8: An update trains the entries named by the returned indices, not the entries selected by the current `predPc` or the current history.
- R9: When a predict and an update address the same entry in the same cycle, the prediction reflects the counter value from before that update.
- R10: While `updValid` is low, the values on the other update inputs change no counter, no history bit and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| predPc | input | IDX_W | Low address bits of the branch being fetched |
| predTaken | output | 1 | Final predicted direction |
| predLocalDir | output | 1 | Direction from the per-address table |
| predGlobalDir | output | 1 | Direction from the history-indexed table |
| predLocalIdx | output | IDX_W | Local table index to keep with the branch |
| predGlobalIdx | output | HIST_LEN | Pattern table index (current history) to keep with the branch |
| predChooseIdx | output | IDX_W | Chooser table index to keep with the branch |
| updValid | input | 1 | A resolved branch is being reported |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| updLocalIdx | input | IDX_W | Local index captured at predict time |
| updGlobalIdx | input | HIST_LEN | Pattern index captured at predict time |
| updChooseIdx | input | IDX_W | Chooser index captured at predict time |
| updLocalDir | input | 1 | Local direction captured at predict time |
| updGlobalDir | input | 1 | Pattern direction captured at predict time |
| updFinalDir | input | 1 | Final direction captured at predict time |
| mispredict | output | 1 | Final guess was wrong, one cycle after the update |

## Verification
The bench uses four outcome streams. A branch that is always taken shows the counter leaving its weak reset state, and a single not-taken after saturation shows that the guess does not flip. A strictly alternating branch defeats the local counter but not the history-indexed table, so it shows the chooser moving over to the pattern predictor. A three-taken, one-not-taken loop mixes both cases and exercises disagreement in both directions. Separate directed steps send an update whose captured indices differ from the address being predicted, and hold garbage on the update inputs with the valid bit low, to show that the stored indices are used and that invalid updates are ignored.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET    = 2'd1;  // weakly not-taken
  localparam ctr_t CHOOSE_RESET = 2'd1;  // weakly favours local

  typedef struct packed {
    logic wrTables;   // train local and pattern counters, shift history
    logic wrChoose;   // train the chooser counter
    logic chooseUp;   // chooser step direction: 1 = toward pattern table
    logic dirTaken;   // resolved outcome
    logic raiseMiss;  // final guess was wrong
  } strobe_t;

  function automatic ctr_t satStep(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic    updValid,
  input  logic    updTaken,
  input  logic    updLocalDir,
  input  logic    updGlobalDir,
  input  logic    updFinalDir,
  output strobe_t strb
);

  always_comb begin
    strb.wrTables  = updValid;
    strb.wrChoose  = updValid && (updLocalDir != updGlobalDir);
    strb.chooseUp  = (updGlobalDir == updTaken);
    strb.dirTaken  = updTaken;
    strb.raiseMiss = updValid && (updFinalDir != updTaken);
  end

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int HIST_LEN = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_W-1:0]    predPc,
  input  strobe_t             strb,
  input  logic [IDX_W-1:0]    updLocalIdx,
  input  logic [HIST_LEN-1:0] updGlobalIdx,
  input  logic [IDX_W-1:0]    updChooseIdx,
  output logic                predLocalDir,
  output logic                predGlobalDir,
  output logic                predTaken,
  output logic [HIST_LEN-1:0] histOut,
  output logic                mispredict
);

  localparam int LOC_N = 1 << IDX_W;
  localparam int GLB_N = 1 << HIST_LEN;

  ctr_t locTab [LOC_N];
  ctr_t chTab  [LOC_N];
  ctr_t gloTab [GLB_N];
  logic [HIST_LEN-1:0] hist;
  logic missQ;

  // Per-address entries: local counter and chooser counter
  for (genvar e = 0; e < LOC_N; e++) begin : g_loc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        locTab[e] <= CTR_RESET;
        chTab[e]  <= CHOOSE_RESET;
      end else begin
        if (strb.wrTables && (updLocalIdx == IDX_W'(e)))
          locTab[e] <= satStep(locTab[e], strb.dirTaken);
        if (strb.wrChoose && (updChooseIdx == IDX_W'(e)))
          chTab[e] <= satStep(chTab[e], strb.chooseUp);
      end
    end
  end

  // History-indexed pattern entries
  for (genvar e = 0; e < GLB_N; e++) begin : g_glb
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        gloTab[e] <= CTR_RESET;
      else if (strb.wrTables && (updGlobalIdx == HIST_LEN'(e)))
        gloTab[e] <= satStep(gloTab[e], strb.dirTaken);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist  <= '0;
      missQ <= 1'b0;
    end else begin
      if (strb.wrTables) hist <= {hist[HIST_LEN-2:0], strb.dirTaken};
      missQ <= strb.raiseMiss;
    end
  end

  ctr_t locCtr, gloCtr, chCtr;

  always_comb begin
    locCtr        = locTab[predPc];
    chCtr         = chTab[predPc];
    gloCtr        = gloTab[hist];
    predLocalDir  = locCtr[1];
    predGlobalDir = gloCtr[1];
    predTaken     = chCtr[1] ? predGlobalDir : predLocalDir;
  end

  assign histOut    = hist;
  assign mispredict = missQ;

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tp_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int HIST_LEN = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_W-1:0]    predPc,
  output logic                predTaken,
  output logic                predLocalDir,
  output logic                predGlobalDir,
  output logic [IDX_W-1:0]    predLocalIdx,
  output logic [HIST_LEN-1:0] predGlobalIdx,
  output logic [IDX_W-1:0]    predChooseIdx,
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [IDX_W-1:0]    updLocalIdx,
  input  logic [HIST_LEN-1:0] updGlobalIdx,
  input  logic [IDX_W-1:0]    updChooseIdx,
  input  logic                updLocalDir,
  input  logic                updGlobalDir,
  input  logic                updFinalDir,
  output logic                mispredict
);

  strobe_t strb;

  tp_ctrl ctrl_i (
    .updValid    (updValid),
    .updTaken    (updTaken),
    .updLocalDir (updLocalDir),
    .updGlobalDir(updGlobalDir),
    .updFinalDir (updFinalDir),
    .strb        (strb)
  );

  tp_datapath #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .predPc       (predPc),
    .strb         (strb),
    .updLocalIdx  (updLocalIdx),
    .updGlobalIdx (updGlobalIdx),
    .updChooseIdx (updChooseIdx),
    .predLocalDir (predLocalDir),
    .predGlobalDir(predGlobalDir),
    .predTaken    (predTaken),
    .histOut      (predGlobalIdx),
    .mispredict   (mispredict)
  );

  assign predLocalIdx  = predPc;
  assign predChooseIdx = predPc;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int IDX_W    = 6,
  parameter int HIST_LEN = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [IDX_W-1:0]    predPc,
  input logic                predTaken,
  input logic                predLocalDir,
  input logic                predGlobalDir,
  input logic [IDX_W-1:0]    predLocalIdx,
  input logic [HIST_LEN-1:0] predGlobalIdx,
  input logic [IDX_W-1:0]    predChooseIdx,
  input logic                updValid,
  input logic                updTaken,
  input logic [IDX_W-1:0]    updLocalIdx,
  input logic [HIST_LEN-1:0] updGlobalIdx,
  input logic [IDX_W-1:0]    updChooseIdx,
  input logic                updLocalDir,
  input logic                updGlobalDir,
  input logic                updFinalDir,
  input logic                mispredict
);

  AST_MISS_ON_WRONG: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (mispredict == ($past(updFinalDir) != $past(updTaken)))); // R7

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> !mispredict); // R7

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (predGlobalIdx == {$past(predGlobalIdx[HIST_LEN-2:0]), $past(updTaken)})); // R4

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(predGlobalIdx)); // R10

  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (predLocalDir == predGlobalDir) |-> (predTaken == predLocalDir)); // R5

  AST_PICK_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (predTaken == predLocalDir) || (predTaken == predGlobalDir)); // R5

endmodule

bind tournament_bp tp_checker #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) chk_i (.*);

// File: tb/tournament_bp_tb_top.sv
`timescale 1ns/100ps
module tournament_bp_tb_top;

  localparam int IW = 6;
  localparam int HL = 6;
  localparam int NL = 1 << IW;
  localparam int NG = 1 << HL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IW-1:0] predPc = '0;
  logic predTaken, predLocalDir, predGlobalDir, mispredict;
  logic [IW-1:0] predLocalIdx, predChooseIdx;
  logic [HL-1:0] predGlobalIdx;
  logic updValid = 1'b0, updTaken = 1'b0;
  logic [IW-1:0] updLocalIdx = '0, updChooseIdx = '0;
  logic [HL-1:0] updGlobalIdx = '0;
  logic updLocalDir = 1'b0, updGlobalDir = 1'b0, updFinalDir = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tournament_bp #(.IDX_W(IW), .HIST_LEN(HL)) dut_i (.*);

  // Scoreboard
  typedef struct { string tag; int sel; int expv; } item_t;
  item_t q[$];
  event doCheck;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  function automatic int readSel(int sel);
    case (sel)
      0: return int'(predTaken);
      1: return int'(predLocalIdx);
      2: return int'(predGlobalIdx);
      3: return int'(predChooseIdx);
      4: return int'(mispredict);
      5: return int'(predLocalDir);
      default: return int'(predGlobalDir);
    endcase
  endfunction

  initial forever begin
    @(doCheck);
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = readSel(it.sel);
      compared++;
      if (act != it.expv) begin
        mismatched++;
        $display("FAIL %s (out %0d): actual %0d expected %0d", it.tag, it.sel, act, it.expv);
      end
    end
  end

  task automatic expect_(string tag, int sel, int v);
    item_t it;
    it.tag = tag; it.sel = sel; it.expv = v;
    q.push_back(it);
  endtask

  task automatic fire();
    -> doCheck;
    #0.5;
  endtask

  // Reference model built from the requirements
  int locM [NL];
  int gloM [NG];
  int chM  [NL];
  int histM = 0;

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    else    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic bit dirOf(int c);
    return c >= 2;
  endfunction

  task automatic modelUpdate(int l, int g, int c, bit ld, bit gd, bit t);
    locM[l] = sat(locM[l], t);
    gloM[g] = sat(gloM[g], t);
    if (ld != gd) chM[c] = sat(chM[c], gd == t);
    histM = ((histM << 1) | int'(t)) & (NG - 1);
  endtask

  // Predict and resolve the same branch in the same cycle
  task automatic step(int pc, bit taken, string tag);
    bit ld, gd, fd;
    int g;
    @(negedge clk);
    g  = histM;
    ld = dirOf(locM[pc]);
    gd = dirOf(gloM[g]);
    fd = (chM[pc] >= 2) ? gd : ld;
    predPc = IW'(pc);
    updLocalIdx = IW'(pc); updGlobalIdx = HL'(g); updChooseIdx = IW'(pc);
    updLocalDir = ld; updGlobalDir = gd; updFinalDir = fd;
    updTaken = taken; updValid = 1'b1;
    #0.5;
    expect_({tag, " R9"}, 0, int'(fd));   // old value seen during same-entry update
    expect_("R2", 1, pc);
    expect_("R4", 2, g);
    expect_("R2", 3, pc);
    expect_("R3", 5, int'(ld));
    expect_("R3", 6, int'(gd));
    fire();
    @(posedge clk);
    modelUpdate(pc, g, pc, ld, gd, taken);
    @(negedge clk);
    updValid = 1'b0;
    #0.5;
    expect_("R7", 4, int'(fd != taken));
    fire();
  endtask

  task automatic predictOnly(int pc, string tag);
    @(negedge clk);
    predPc = IW'(pc);
    #0.5;
    expect_(tag, 0, int'((chM[pc] >= 2) ? dirOf(gloM[histM]) : dirOf(locM[pc])));
    expect_(tag, 2, histM);
    expect_(tag, 4, 0);
    fire();
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin locM[i] = 1; chM[i] = 1; end
    for (int i = 0; i < NG; i++) gloM[i] = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    predPc = IW'(5);
    #0.5;
    expect_("R1", 0, 0);
    expect_("R1", 2, 0);
    expect_("R1", 4, 0);
    expect_("R1", 5, 0);
    expect_("R1", 6, 0);
    fire();

    // R3: always-taken branch, then one not-taken after saturation
    for (int i = 0; i < 4; i++) step(3, 1'b1, "R3");
    step(3, 1'b0, "R3");
    predictOnly(3, "R3");

    // R6: alternating branch moves the chooser toward the pattern table
    for (int i = 0; i < 40; i++) step(10, bit'(i % 2), "R6");
    for (int i = 0; i < 4; i++) step(10, bit'(i % 2), "R5");

    // Loop pattern: three taken, one not-taken
    for (int i = 0; i < 32; i++) step(12, bit'((i % 4) != 3), "R5");

    // R10: garbage on update inputs with valid low
    @(negedge clk);
    updValid = 1'b0; updTaken = 1'b1; updLocalIdx = IW'(3); updGlobalIdx = '1;
    updChooseIdx = IW'(3); updLocalDir = 1'b0; updGlobalDir = 1'b1; updFinalDir = 1'b0;
    @(negedge clk);
    predictOnly(3, "R10");
    predictOnly(12, "R10");

    // R8: update entry 20 using captured indices while predicting 40
    for (int k = 0; k < 2; k++) begin
      bit ld, gd, fd;
      int g;
      @(negedge clk);
      g  = histM;
      ld = dirOf(locM[20]);
      gd = dirOf(gloM[g]);
      fd = (chM[20] >= 2) ? gd : ld;
      predPc = IW'(40);
      updLocalIdx = IW'(20); updGlobalIdx = HL'(g); updChooseIdx = IW'(20);
      updLocalDir = ld; updGlobalDir = gd; updFinalDir = fd;
      updTaken = 1'b1; updValid = 1'b1;
      @(posedge clk);
      modelUpdate(20, g, 20, ld, gd, 1'b1);
    end
    @(negedge clk);
    updValid = 1'b0;
    @(negedge clk);
    predictOnly(20, "R8");
    predictOnly(40, "R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule